// File: doc/BRIEF.md
# Four-Stream Packing DMA Engine

This block is a small DMA engine that runs up to four transfer streams. Each stream has its own source address, destination address, word count and control word. A stream can copy memory to memory. It can also move data from a peripheral into memory, or from memory out to a peripheral. In the two peripheral-paced modes, each burst waits for that stream's request line. The engine answers with a one-cycle acknowledge once the burst has been written.

The source side and the destination side are configured separately. Each has its own access width (byte, half-word or word) and its own address mode (advance after every beat, or stay put, as a peripheral data register needs). One burst of up to sixteen words is read into a 64-byte staging buffer. The buffer is then drained at the destination width, so any source width can be paired with any destination width. Streams are served one burst at a time, and the lowest-numbered ready stream always goes first. When a stream's count runs out, it raises a done interrupt. When the bus reports an error, only that stream is stopped, and it raises an error interrupt.

Top module: `dma_streams`

## Requirements
- R1: After reset the engine makes no bus request, and all acknowledge, done and error outputs are low.
- R2: Configuration writes address a stream and one of four registers: 0 holds the source address, 1 the destination address, 2 the count in 32-bit words, and 3 the control word. In the control word, bit 0 is enable, [2:1] is the mode (0 memory-to-memory, 1 peripheral-to-memory, 2 memory-to-peripheral), [4:3] is the source width and [6:5] the destination width (0 byte, 1 half-word, 2 word), bit 7 advances the source address, bit 8 advances the destination address, and [12:9] holds the burst length minus one, in words. A stream moves exactly count×4 bytes.
- R3: Bytes arrive at the destination in the order they were read, whatever the two widths are. Bus data is low-justified: a read uses only its low lanes, and a write drives its unused upper lanes with zero.
- R4: When a side's advance bit is clear, every beat on that side uses the same address. When it is set, the address grows by that side's width after each accepted beat, and the growth carries over into later bursts.
- R5: A burst is min(burst length, remaining count) words. All of its reads complete before its first write.
- R6: When more than one stream is ready, the lowest-numbered one gets the next burst.
- R7: A peripheral-paced stream makes no bus access while its request line is low. Each completed burst gives exactly one single-cycle pulse on that stream's acknowledge.
- R8: When the count reaches zero, the stream clears its enable and sets its done flag. A stream enabled with a zero count finishes at once, with no bus traffic. Writing the control register clears both of that stream's flags.
- R9: A bus error ends the current access and stops only the stream involved: its enable clears and its error flag sets. The other streams carry on.
- R10: While a request waits for ready or error, the address, direction, size and write data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_stream | input | 2 | Stream being configured |
| cfg_reg | input | 2 | Register index within the stream |
| cfg_wdata | input | 32 | Configuration write data |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address |
| bus_size | output | 2 | Access width: 0 byte, 1 half-word, 2 word |
| bus_wdata | output | 32 | Write data, low-justified |
| bus_rdata | input | 32 | Read data, low-justified |
| bus_ready | input | 1 | Access completes this cycle |
| bus_err | input | 1 | Access fails this cycle |
| per_req | input | 4 | Peripheral burst request, one per stream |
| per_ack | output | 4 | Burst-complete pulse, one per stream |
| done_irq | output | 4 | Count exhausted, one per stream |
| err_irq | output | 4 | Bus error seen, one per stream |

## Verification
The assertions assume a bus that never raises ready and error in the same cycle. They also assume that software does not rewrite a stream's registers while that stream is enabled. The bench's memory model keeps to both: it returns an error only for one reserved address window, and only in place of ready. Every test configures a stream fully while it is idle and then writes its control word last. Counts are always whole words and bursts never exceed sixteen words, so the staging buffer never holds more than one burst.

// File: rtl/dma_streams.sv
module dma_streams #(
  parameter int NS = 4,
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_stream,
  input  logic [1:0]    cfg_reg,
  input  logic [31:0]   cfg_wdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_size,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  input  logic          bus_ready,
  input  logic          bus_err,
  input  logic [NS-1:0] per_req,
  output logic [NS-1:0] per_ack,
  output logic [NS-1:0] done_irq,
  output logic [NS-1:0] err_irq
);
  localparam int FB = 4 << BW;
  localparam int IW = BW + 2;
  localparam int PW = BW + 3;
  localparam int KW = 9 + BW;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  logic [AW-1:0] src_a [NS];
  logic [AW-1:0] dst_a [NS];
  logic [CW-1:0] cnt   [NS];
  logic [KW-1:0] ctl   [NS];
  logic [7:0]    fifo  [FB];

  st_t           st;
  logic [1:0]    cur;
  logic [IW-1:0] wp, rp;
  logic [PW-1:0] rd_left, wr_left;
  logic [BW:0]   cwr;

  logic [1:0]    pick;
  logic          any;
  logic [BW:0]   blen, chunk;

  function automatic logic [2:0] nbytes(input logic [1:0] w);
    return (w == 2'd0) ? 3'd1 : (w == 2'd1) ? 3'd2 : 3'd4;
  endfunction

  function automatic logic [1:0] szcode(input logic [1:0] w);
    return (w == 2'd3) ? 2'd2 : w;
  endfunction

  function automatic logic paced(input logic [1:0] m);
    return (m == 2'd1) || (m == 2'd2);
  endfunction

  always_comb begin
    pick = '0;
    any  = 1'b0;
    for (int i = NS - 1; i >= 0; i--)
      if (ctl[i][0] && (!paced(ctl[i][2:1]) || per_req[i])) begin
        pick = 2'(i);
        any  = 1'b1;
      end
  end

  assign blen  = {1'b0, ctl[pick][9 +: BW]} + 1'b1;
  assign chunk = (cnt[pick] < CW'(blen)) ? cnt[pick][BW:0] : blen;

  logic [2:0] snb, dnb;
  assign snb = nbytes(ctl[cur][4:3]);
  assign dnb = nbytes(ctl[cur][6:5]);

  assign bus_req  = (st == S_RD) || (st == S_WR);
  assign bus_we   = (st == S_WR);
  assign bus_addr = (st == S_WR) ? dst_a[cur] : src_a[cur];
  assign bus_size = (st == S_WR) ? szcode(ctl[cur][6:5]) : szcode(ctl[cur][4:3]);

  always_comb begin
    bus_wdata = '0;
    if (st == S_WR)
      for (int k = 0; k < 4; k++)
        if (k < int'(dnb)) bus_wdata[8*k +: 8] = fifo[rp + IW'(k)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0;
      wp <= '0;
      rp <= '0;
      rd_left <= '0;
      wr_left <= '0;
      cwr <= '0;
      per_ack <= '0;
      done_irq <= '0;
      err_irq <= '0;
      for (int i = 0; i < NS; i++) begin
        src_a[i] <= '0;
        dst_a[i] <= '0;
        cnt[i] <= '0;
        ctl[i] <= '0;
      end
      for (int j = 0; j < FB; j++) fifo[j] <= '0;
    end else begin
      per_ack <= '0;
      if (cfg_we) begin
        case (cfg_reg)
          2'd0: src_a[cfg_stream] <= cfg_wdata[AW-1:0];
          2'd1: dst_a[cfg_stream] <= cfg_wdata[AW-1:0];
          2'd2: cnt[cfg_stream] <= cfg_wdata[CW-1:0];
          default: begin
            ctl[cfg_stream] <= cfg_wdata[KW-1:0];
            done_irq[cfg_stream] <= 1'b0;
            err_irq[cfg_stream] <= 1'b0;
          end
        endcase
      end
      case (st)
        S_IDLE: if (any) begin
          cur <= pick;
          if (cnt[pick] == '0) begin
            ctl[pick][0] <= 1'b0;
            done_irq[pick] <= 1'b1;
          end else begin
            cwr <= chunk;
            rd_left <= {chunk, 2'b00};
            wr_left <= {chunk, 2'b00};
            wp <= '0;
            rp <= '0;
            st <= S_RD;
          end
        end
        S_RD: if (bus_err) begin
          ctl[cur][0] <= 1'b0;
          err_irq[cur] <= 1'b1;
          st <= S_IDLE;
        end else if (bus_ready) begin
          for (int k = 0; k < 4; k++)
            if (k < int'(snb)) fifo[wp + IW'(k)] <= bus_rdata[8*k +: 8];
          wp <= wp + IW'(snb);
          if (ctl[cur][7]) src_a[cur] <= src_a[cur] + AW'(snb);
          rd_left <= rd_left - PW'(snb);
          if (rd_left == PW'(snb)) st <= S_WR;
        end
        S_WR: if (bus_err) begin
          ctl[cur][0] <= 1'b0;
          err_irq[cur] <= 1'b1;
          st <= S_IDLE;
        end else if (bus_ready) begin
          rp <= rp + IW'(dnb);
          if (ctl[cur][8]) dst_a[cur] <= dst_a[cur] + AW'(dnb);
          wr_left <= wr_left - PW'(dnb);
          if (wr_left == PW'(dnb)) begin
            st <= S_IDLE;
            cnt[cur] <= cnt[cur] - CW'(cwr);
            if (paced(ctl[cur][2:1])) per_ack[cur] <= 1'b1;
            if (cnt[cur] == CW'(cwr)) begin
              ctl[cur][0] <= 1'b0;
              done_irq[cur] <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_streams_chk.sv
module dma_streams_chk #(
  parameter int NS = 4,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [1:0]    bus_size,
  input logic [31:0]   bus_wdata,
  input logic          bus_ready,
  input logic          bus_err,
  input logic [NS-1:0] per_ack,
  input logic [NS-1:0] done_irq,
  input logic [NS-1:0] err_irq
);
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready && !bus_err |=>
      bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_size) && $stable(bus_wdata));

  a_r9_err_release: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_err |=> !bus_req);

  a_r3_zero_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && bus_size != 2'd2 |->
      (bus_size == 2'd0 ? bus_wdata[31:8] == '0 : bus_wdata[31:16] == '0));

  a_r2_size_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> bus_size != 2'd3);

  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    per_ack != '0 |=> per_ack == '0);

  a_r6_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_ack));

  a_r8_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_irq) && $past(bus_req) |-> $past(bus_we) && $past(bus_ready));

  a_r9_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_irq) |-> $past(bus_req) && $past(bus_err));
endmodule

bind dma_streams dma_streams_chk #(.NS(NS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
  .bus_ready(bus_ready), .bus_err(bus_err), .per_ack(per_ack),
  .done_irq(done_irq), .err_irq(err_irq)
);

// File: tb/dma_streams_tb.sv
module dma_streams_tb;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [1:0] cfg_stream = 0, cfg_reg = 0;
  logic [31:0] cfg_wdata = 0;
  logic bus_req, bus_we;
  logic [31:0] bus_addr, bus_wdata;
  logic [1:0] bus_size;
  logic [31:0] bus_rdata = 0;
  logic bus_ready = 0, bus_err = 0;
  logic [3:0] per_req = 0, per_ack, done_irq, err_irq;

  always #2 clk = ~clk;

  dma_streams u_dut (.*);

  int errors = 0, checks = 0;
  bit finished = 0;
  logic [7:0] mem [4096];
  int pn = 0, pm = 0;
  int qra[$], qrs[$], qwa[$], qws[$], qwd[$], qch[$];
  int rdrun = 0, acks[4];
  bit held = 0, slow = 0, reqseen = 0;
  logic [31:0] held_addr;

  function automatic int fmem(int a); return (a * 7 + 3) & 255; endfunction
  function automatic int nb(int w); return w == 0 ? 1 : (w == 1 ? 2 : 4); endfunction
  function automatic int pbyte(int n, int l); return (4 * n + l) & 255; endfunction
  function automatic bit isper(int a); return a >= 'h800 && a < 'hA00; endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus responder and per-clock comparison against the model queues
  always @(negedge clk) begin
    bus_ready = 0; bus_err = 0;
    for (int i = 0; i < 4; i++) acks[i] += per_ack[i];
    if (bus_req) begin
      reqseen = 1;
      if (held) chk(bus_addr == held_addr, "R10 addr held", bus_addr, held_addr);
      if (bus_addr >= 'hE00 && bus_addr < 'hF00) begin
        bus_err = 1; held = 0;
      end else if (slow && !held) begin
        held = 1; held_addr = bus_addr;
      end else begin
        held = 0; bus_ready = 1;
        if (bus_we) begin
          if (rdrun != 0) begin
            chk(qch.size() != 0 && qch[0] == rdrun, "R5 reads per burst", rdrun,
                qch.size() ? qch[0] : -1);
            if (qch.size()) void'(qch.pop_front());
            rdrun = 0;
          end
          if (qwa.size() == 0) chk(0, "R2 unexpected write", bus_addr, 0);
          else begin
            chk(bus_addr == qwa[0], "R4 write address", bus_addr, qwa[0]);
            chk(bus_size == qws[0], "R2 write size", bus_size, qws[0]);
            chk(bus_wdata == qwd[0], "R3 write data", bus_wdata, qwd[0]);
            void'(qwa.pop_front()); void'(qws.pop_front()); void'(qwd.pop_front());
          end
          if (!isper(bus_addr))
            for (int k = 0; k < nb(bus_size); k++) mem[(bus_addr + k) & 4095] = bus_wdata[8*k +: 8];
        end else begin
          rdrun++;
          if (qra.size() == 0) chk(0, "R2 unexpected read", bus_addr, 0);
          else begin
            chk(bus_addr == qra[0], "R4 read address", bus_addr, qra[0]);
            chk(bus_size == qrs[0], "R2 read size", bus_size, qrs[0]);
            void'(qra.pop_front()); void'(qrs.pop_front());
          end
          for (int k = 0; k < 4; k++)
            bus_rdata[8*k +: 8] = k >= nb(bus_size) ? 8'hEE :
              (isper(bus_addr) ? 8'(pbyte(pn, k)) : mem[(bus_addr + k) & 4095]);
          if (isper(bus_addr)) pn++;
        end
      end
    end else held = 0;
  end

  task automatic plan(int src, int dst, int words, int sw, int dw, bit si, bit di, int bl);
    int bytes[$];
    int s = nb(sw), d = nb(dw), left = words;
    for (int j = 0; j < words * 4 / s; j++) begin
      int a = src + (si ? j * s : 0);
      qra.push_back(a); qrs.push_back(sw);
      for (int l = 0; l < s; l++) bytes.push_back(isper(a) ? pbyte(pm, l) : fmem(a + l));
      if (isper(a)) pm++;
    end
    for (int k = 0; k < words * 4 / d; k++) begin
      int v = 0;
      for (int l = 0; l < d; l++) v |= bytes[k * d + l] << (8 * l);
      qwa.push_back(dst + (di ? k * d : 0)); qws.push_back(dw); qwd.push_back(v);
    end
    while (left > 0) begin
      int c = left < bl ? left : bl;
      qch.push_back(c * 4 / s);
      left -= c;
    end
  endtask

  task automatic cfgw(int s, int r, int d);
    @(negedge clk);
    cfg_we = 1; cfg_stream = 2'(s); cfg_reg = 2'(r); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  function automatic int ctlv(int md, int sw, int dw, bit si, bit di, int bl);
    return 1 | md << 1 | sw << 3 | dw << 5 | int'(si) << 7 | int'(di) << 8 | (bl - 1) << 9;
  endfunction

  task automatic setup(int s, int src, int dst, int words);
    cfgw(s, 0, src); cfgw(s, 1, dst); cfgw(s, 2, words);
  endtask

  task automatic wait_flag(int s);
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (done_irq[s] || err_irq[s]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic end_test(string req);
    chk(qra.size() == 0 && qwa.size() == 0, req, qra.size() + qwa.size(), 0);
    if (rdrun != 0 || qch.size() != 0) chk(0, "R5 burst leftovers", qch.size(), 0);
    rdrun = 0; qch.delete();
  endtask

  initial begin
    for (int i = 0; i < 4; i++) acks[i] = 0;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(fmem(i));
    repeat (3) @(negedge clk);
    chk(!bus_req && per_ack == 0 && done_irq == 0 && err_irq == 0, "R1 reset outputs",
        {bus_req, per_ack, done_irq, err_irq}, 0);
    rst_n = 1;

    // word to word, burst 4, incrementing
    setup(0, 'h100, 'h400, 8); plan('h100, 'h400, 8, 2, 2, 1, 1, 4);
    cfgw(0, 3, ctlv(0, 2, 2, 1, 1, 4)); wait_flag(0);
    end_test("R2 all words moved");
    chk(done_irq[0] && !err_irq[0], "R8 done flag", done_irq, 1);
    cfgw(0, 3, 0); @(negedge clk);
    chk(done_irq[0] == 0, "R8 flag cleared by control write", done_irq, 0);

    // byte source to word destination, burst 2, wait states
    slow = 1;
    setup(1, 'h203, 'h480, 5); plan('h203, 'h480, 5, 0, 2, 1, 1, 2);
    cfgw(1, 3, ctlv(0, 0, 2, 1, 1, 2)); wait_flag(1);
    end_test("R3 byte to word pack");
    chk(done_irq[1], "R8 done byte to word", done_irq, 2);
    slow = 0;

    // word source to half-word destination, burst longer than count
    setup(2, 'h300, 'h500, 3); plan('h300, 'h500, 3, 2, 1, 1, 1, 16);
    cfgw(2, 3, ctlv(0, 2, 1, 1, 1, 16)); wait_flag(2);
    end_test("R3 word to half unpack");
    chk(done_irq[2], "R5 short final chunk done", done_irq, 4);

    // peripheral to memory: frozen half-word source, paced
    acks[3] = 0; reqseen = 0;
    setup(3, 'h800, 'h540, 6); plan('h800, 'h540, 6, 1, 2, 0, 1, 3);
    cfgw(3, 3, ctlv(1, 1, 2, 0, 1, 3));
    repeat (20) @(negedge clk);
    chk(!reqseen, "R7 no access without request", reqseen, 0);
    per_req[3] = 1; wait_flag(3); per_req[3] = 0;
    end_test("R4 frozen source stream");
    chk(acks[3] == 2, "R7 one ack per burst", acks[3], 2);
    chk(done_irq[3], "R8 paced stream done", done_irq, 8);

    // priority: streams 0 and 2 memory to peripheral, released together
    acks[0] = 0; acks[2] = 0;
    setup(0, 'h600, 'h900, 4); setup(2, 'h680, 'h940, 4);
    plan('h600, 'h900, 4, 2, 0, 1, 0, 2);
    plan('h680, 'h940, 4, 2, 2, 1, 0, 4);
    cfgw(2, 3, ctlv(2, 2, 2, 1, 0, 4)); cfgw(0, 3, ctlv(2, 2, 0, 1, 0, 2));
    @(negedge clk); per_req[0] = 1; per_req[2] = 1;
    wait_flag(2); per_req = 0;
    end_test("R6 lowest stream first");
    chk(acks[0] == 2 && acks[2] == 1, "R7 ack counts", acks[0] * 16 + acks[2], 'h21);
    chk(done_irq[0] && done_irq[2], "R6 both done", done_irq, 5);

    // error on stream 1, stream 3 unaffected
    setup(1, 'hE00, 'h700, 2); setup(3, 'h780, 'h740, 2);
    plan('h780, 'h740, 2, 1, 0, 1, 1, 2);
    cfgw(3, 3, ctlv(0, 1, 0, 1, 1, 2) & ~1); cfgw(1, 3, ctlv(0, 2, 2, 1, 1, 2));
    wait_flag(1);
    chk(err_irq[1] && !done_irq[1], "R9 error flag on failing stream", {err_irq[1], done_irq[1]}, 2);
    cfgw(3, 3, ctlv(0, 1, 0, 1, 1, 2)); wait_flag(3);
    end_test("R9 other stream continues");
    chk(done_irq[3] && !err_irq[3], "R9 clean stream done", {done_irq[3], err_irq[3]}, 2);
    chk(err_irq[1], "R9 error flag holds", err_irq, 2);

    // zero count finishes at once
    reqseen = 0;
    cfgw(2, 2, 0); cfgw(2, 3, ctlv(0, 2, 2, 1, 1, 4));
    repeat (3) @(negedge clk);
    chk(done_irq[2] && !reqseen, "R8 zero count immediate", {done_irq[2], reqseen}, 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule